// File: doc/BRIEF.md
# Event Monitor Register Bank

This block is the software-facing register bank for four hardware event monitors. Monitors 0 and 1 watch for supply glitches and monitors 2 and 3 watch clocks. The four behave the same at the register level. Each detector is outside the block and reports an event as a one-cycle pulse on its own input bit. The bank turns each pulse into two sticky records: a per-monitor status flag and a per-monitor interrupt flag. Software clears each record on its own by writing a one to it. An interrupt enable mask selects which interrupt flags reach the single interrupt output.

The bank also holds each detector's configuration, which it drives out on two pins per detector: a detector enable and an active/passive mode select. It has a one-way lock that forbids test-mode entry. Any nonzero write sets the lock, and only a reset clears it. The bus is a simple word-wide interface with a write strobe, a read strobe and a 7-bit byte address. Read data appears on the cycle after the read strobe.

Top module: `evmon_regbank`

## Requirements
- R1: After synchronous reset, the following are all zero: every register, `det_enable`, `det_active`, `test_lock`, `irq` and `bus_rdata`.
- R2: Monitor n's control word is at byte address 8n (n = 0..3). Bit 0 is the detector enable and drives `det_enable[n]`. Bit 4 is the mode select (1 = active, 0 = passive) and drives `det_active[n]`. All other bits read as zero. Both output pins follow a write on the next cycle.
- R3: When `evt_in[n]` is high on a clock edge and monitor n's enable bit is 1, the status flag of monitor n and interrupt flag n are both set after that edge. While the enable bit is 0, the pulse is ignored.
- R4: Monitor n's status word is at byte address 8n+4 with its flag in bit 0. Writing 1 to bit 0 clears the flag. Writing 0 leaves it unchanged.
- R5: If an event that is let through arrives on the same edge as a write-one-to-clear of the same flag (status or interrupt), the flag remains set.
- R6: The interrupt flag word is at byte address 0x40, with flag n in bit n. Writing 1 to bit n clears flag n and writing 0 leaves it unchanged. Bits 31:4 read as zero.
- R7: The interrupt enable word is at byte address 0x44. Bits 3:0 are read/write with bit n for monitor n, and bits 31:4 read as zero.
- R8: `irq` is high exactly when some monitor n has both interrupt flag n and enable bit n set. It is derived without an extra register from the flag and enable state.
- R9: The lock word is at byte address 0x20 and reads back its state in bit 0, which also drives `test_lock`. A write with any nonzero data sets the lock. A write of zero has no effect. No write clears the lock.
- R10: The following addresses are reserved: byte addresses 0x24 to 0x3F, any address from 0x48 upward, and any address whose low two bits are not zero. Reads of them return zero and writes to them change nothing.
- R11: `bus_rdata` carries the data for the address presented with `bus_rd` on the cycle after that strobe, and reflects the state before that edge. On the cycle after an edge without `bus_rd`, it is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_rd | input | 1 | Read strobe for one cycle |
| bus_addr | input | 7 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after `bus_rd` |
| evt_in | input | 4 | One-cycle event pulse per monitor |
| det_enable | output | 4 | Detector enable per monitor |
| det_active | output | 4 | Active-mode select per monitor |
| test_lock | output | 1 | High once test-mode entry is forbidden |
| irq | output | 1 | Masked OR of the interrupt flags |

## Verification
Directed sequences come first. They show that a pulse on a disabled monitor differs from one on an enabled monitor, and that a zero write to a flag differs from a one write. They show that an event landing on the same edge as a clear differs from a clear alone. They also show that zero and nonzero writes to the lock word behave differently, and that reserved and misaligned addresses read zero. A long random phase then follows, mixing writes, reads and event pulses across every defined word and several reserved ones. This phase catches interactions between monitors, such as a clear on one bit disturbing its neighbours, or the interrupt output ignoring the enable mask. It compares every read and every output pin against a model in the bench.

// File: rtl/evmon_pkg.sv
package evmon_pkg;

    localparam int NUM_MON     = 4;
    localparam int GRP_W       = $clog2(NUM_MON);
    localparam int BUS_AW      = 7;
    localparam int BUS_DW      = 32;
    localparam int GRP_BYTES   = 8;
    localparam int GRP_SPAN    = NUM_MON * GRP_BYTES;
    localparam int CTL_EN_POS  = 0;
    localparam int CTL_ACT_POS = 4;

    localparam logic [BUS_AW-1:0] OFS_LOCK = 7'h20;
    localparam logic [BUS_AW-1:0] OFS_IFLG = 7'h40;
    localparam logic [BUS_AW-1:0] OFS_IEN  = 7'h44;

    typedef enum logic [2:0] {
        RK_CTL,
        RK_STS,
        RK_LOCK,
        RK_IFLG,
        RK_IEN,
        RK_NONE
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e        kind;
        logic [GRP_W-1:0] grp;
    } reg_sel_t;

    typedef struct packed {
        logic act;
        logic en;
    } mon_ctl_t;

    function automatic reg_sel_t decode_addr(input logic [BUS_AW-1:0] a);
        reg_sel_t s;
        s.kind = RK_NONE;
        s.grp  = '0;
        if (a[1:0] == 2'b00) begin
            if (int'(a) < GRP_SPAN) begin
                s.grp  = a[GRP_W+2:3];
                s.kind = a[2] ? RK_STS : RK_CTL;
            end else if (a == OFS_LOCK) begin
                s.kind = RK_LOCK;
            end else if (a == OFS_IFLG) begin
                s.kind = RK_IFLG;
            end else if (a == OFS_IEN) begin
                s.kind = RK_IEN;
            end
        end
        return s;
    endfunction

    function automatic logic [BUS_DW-1:0] pack_ctl(input mon_ctl_t c);
        logic [BUS_DW-1:0] r;
        r              = '0;
        r[CTL_EN_POS]  = c.en;
        r[CTL_ACT_POS] = c.act;
        return r;
    endfunction

    function automatic mon_ctl_t unpack_ctl(input logic [BUS_DW-1:0] d);
        mon_ctl_t c;
        c.en  = d[CTL_EN_POS];
        c.act = d[CTL_ACT_POS];
        return c;
    endfunction

endpackage

// File: rtl/evmon_decode.sv
module evmon_decode
    import evmon_pkg::*;
(
    input  logic                 wr,
    input  logic [BUS_AW-1:0]    addr,
    input  logic [NUM_MON-1:0]   wbits,
    output reg_sel_t             sel,
    output logic [NUM_MON-1:0]   ctl_wr,
    output logic [NUM_MON-1:0]   sts_clr,
    output logic [NUM_MON-1:0]   iflg_clr,
    output logic                 ien_wr,
    output logic                 lock_wr
);

    assign sel = decode_addr(addr);

    for (genvar g = 0; g < NUM_MON; g++) begin : g_strobe
        logic hit;
        assign hit         = wr && (sel.grp == GRP_W'(g));
        assign ctl_wr[g]   = hit && (sel.kind == RK_CTL);
        assign sts_clr[g]  = hit && (sel.kind == RK_STS) && wbits[0];
        assign iflg_clr[g] = wr && (sel.kind == RK_IFLG) && wbits[g];
    end

    assign ien_wr  = wr && (sel.kind == RK_IEN);
    assign lock_wr = wr && (sel.kind == RK_LOCK);

endmodule

// File: rtl/evmon_channel.sv
module evmon_channel
    import evmon_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     ctl_wr,
    input  mon_ctl_t ctl_d,
    input  logic     sts_clr,
    input  logic     iflg_clr,
    input  logic     evt,
    output mon_ctl_t ctl_q,
    output logic     sts_q,
    output logic     iflg_q
);

    logic hit;
    assign hit = evt && ctl_q.en;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q  <= '0;
            sts_q  <= 1'b0;
            iflg_q <= 1'b0;
        end else begin
            if (ctl_wr) begin
                ctl_q <= ctl_d;
            end
            sts_q  <= hit | (sts_q & ~sts_clr);
            iflg_q <= hit | (iflg_q & ~iflg_clr);
        end
    end

    AST_EVT_SETS: assert property (@(posedge clk) disable iff (rst)
        (evt && ctl_q.en) |=> (sts_q && iflg_q));  // R3
    AST_DIS_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (!ctl_q.en && !sts_clr) |=> $stable(sts_q));  // R3
    AST_EVT_BEATS_CLR: assert property (@(posedge clk) disable iff (rst)
        (evt && ctl_q.en && sts_clr && iflg_clr) |=> (sts_q && iflg_q));  // R5
    AST_CLR_DROPS: assert property (@(posedge clk) disable iff (rst)
        (!evt && sts_clr) |=> !sts_q);  // R4

endmodule

// File: rtl/evmon_lock.sv
module evmon_lock
    import evmon_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [BUS_DW-1:0] wdata,
    output logic              locked
);

    always_ff @(posedge clk) begin
        if (rst) begin
            locked <= 1'b0;
        end else if (wr && (wdata != '0)) begin
            locked <= 1'b1;
        end
    end

    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (rst)
        locked |=> locked);  // R9
    AST_LOCK_ZERO_WR: assert property (@(posedge clk) disable iff (rst)
        (!locked && !(wr && (wdata != '0))) |=> !locked);  // R9

endmodule

// File: rtl/evmon_regbank.sv
module evmon_regbank
    import evmon_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [BUS_AW-1:0]  bus_addr,
    input  logic [BUS_DW-1:0]  bus_wdata,
    output logic [BUS_DW-1:0]  bus_rdata,
    input  logic [NUM_MON-1:0] evt_in,
    output logic [NUM_MON-1:0] det_enable,
    output logic [NUM_MON-1:0] det_active,
    output logic               test_lock,
    output logic               irq
);

    reg_sel_t             sel;
    logic [NUM_MON-1:0]   ctl_wr, sts_clr, iflg_clr;
    logic                 ien_wr, lock_wr;
    mon_ctl_t             ctl_v [NUM_MON];
    logic [NUM_MON-1:0]   sts_v, iflg_v;
    logic [NUM_MON-1:0]   ien_q;
    mon_ctl_t             ctl_d;

    assign ctl_d = unpack_ctl(bus_wdata);

    evmon_decode u_dec (
        .wr       (bus_wr),
        .addr     (bus_addr),
        .wbits    (bus_wdata[NUM_MON-1:0]),
        .sel      (sel),
        .ctl_wr   (ctl_wr),
        .sts_clr  (sts_clr),
        .iflg_clr (iflg_clr),
        .ien_wr   (ien_wr),
        .lock_wr  (lock_wr)
    );

    for (genvar g = 0; g < NUM_MON; g++) begin : g_mon
        evmon_channel u_ch (
            .clk      (clk),
            .rst      (rst),
            .ctl_wr   (ctl_wr[g]),
            .ctl_d    (ctl_d),
            .sts_clr  (sts_clr[g]),
            .iflg_clr (iflg_clr[g]),
            .evt      (evt_in[g]),
            .ctl_q    (ctl_v[g]),
            .sts_q    (sts_v[g]),
            .iflg_q   (iflg_v[g])
        );
        assign det_enable[g] = ctl_v[g].en;
        assign det_active[g] = ctl_v[g].act;
    end

    evmon_lock u_lock (
        .clk    (clk),
        .rst    (rst),
        .wr     (lock_wr),
        .wdata  (bus_wdata),
        .locked (test_lock)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ien_q <= '0;
        end else if (ien_wr) begin
            ien_q <= bus_wdata[NUM_MON-1:0];
        end
    end

    assign irq = |(iflg_v & ien_q);

    always_ff @(posedge clk) begin
        if (rst || !bus_rd) begin
            bus_rdata <= '0;
        end else begin
            unique case (sel.kind)
                RK_CTL:  bus_rdata <= pack_ctl(ctl_v[sel.grp]);
                RK_STS:  bus_rdata <= {{(BUS_DW-1){1'b0}}, sts_v[sel.grp]};
                RK_LOCK: bus_rdata <= {{(BUS_DW-1){1'b0}}, test_lock};
                RK_IFLG: bus_rdata <= {{(BUS_DW-NUM_MON){1'b0}}, iflg_v};
                RK_IEN:  bus_rdata <= {{(BUS_DW-NUM_MON){1'b0}}, ien_q};
                default: bus_rdata <= '0;
            endcase
        end
    end

    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
        (ien_q == '0) |-> !irq);  // R8
    AST_IRQ_FLAGGED: assert property (@(posedge clk) disable iff (rst)
        (iflg_v == '0) |-> !irq);  // R8
    AST_RDATA_IDLE: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> (bus_rdata == '0));  // R11
    AST_RSVD_READ: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && sel.kind == RK_NONE) |=> (bus_rdata == '0));  // R10

endmodule

// File: tb/sim_evmon_regbank.sv
module sim_evmon_regbank;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [6:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  evt_in = '0;
    logic [3:0]  det_enable, det_active;
    logic        test_lock, irq;

    always #4 clk = ~clk;  // 125 MHz

    evmon_regbank u0 (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .evt_in(evt_in), .det_enable(det_enable), .det_active(det_active),
        .test_lock(test_lock), .irq(irq)
    );

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    // bench model
    logic [3:0] m_en = '0, m_act = '0, m_sts = '0, m_iflg = '0, m_ien = '0;
    logic       m_lock = 1'b0;
    logic [31:0] exp_rd = '0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] model_read(input logic [6:0] a);
        logic [4:0] w = a[6:2];
        if (a[1:0] != 2'b00) return 32'h0;
        if (w < 5'd8) begin
            int g = int'(w[2:1]);
            if (w[0]) return {31'h0, m_sts[g]};
            return {27'h0, m_act[g], 3'b000, m_en[g]};
        end
        if (w == 5'd8)  return {31'h0, m_lock};
        if (w == 5'd16) return {28'h0, m_iflg};
        if (w == 5'd17) return {28'h0, m_ien};
        return 32'h0;
    endfunction

    function automatic void model_apply(input logic wr, input logic [6:0] a,
                                        input logic [31:0] d, input logic [3:0] e);
        logic [4:0] w = a[6:2];
        logic ok = (a[1:0] == 2'b00);
        logic [3:0] nen = m_en, nact = m_act, nsts = m_sts, niflg = m_iflg;
        for (int i = 0; i < 4; i++) begin
            logic hit = e[i] & m_en[i];
            logic sclr = wr && ok && (w == 5'(2*i+1)) && d[0];
            logic fclr = wr && ok && (w == 5'd16) && d[i];
            nsts[i]  = hit | (m_sts[i] & ~sclr);
            niflg[i] = hit | (m_iflg[i] & ~fclr);
            if (wr && ok && w == 5'(2*i)) begin
                nen[i]  = d[0];
                nact[i] = d[4];
            end
        end
        if (wr && ok && w == 5'd17) m_ien = d[3:0];
        if (wr && ok && w == 5'd8 && d != 0) m_lock = 1'b1;
        m_en = nen; m_act = nact; m_sts = nsts; m_iflg = niflg;
    endfunction

    // one cycle: drive at negedge, edge, arrive at next negedge
    task automatic step(input logic wr, input logic rd, input logic [6:0] a,
                        input logic [31:0] d, input logic [3:0] e);
        bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d; evt_in = e;
        exp_rd = rd ? model_read(a) : 32'h0;
        model_apply(wr, a, d, e);
        @(negedge clk);
        bus_wr = 0; bus_rd = 0; evt_in = 0;
    endtask

    task automatic wr_reg(input logic [6:0] a, input logic [31:0] d);
        step(1, 0, a, d, 4'h0);
    endtask

    task automatic rd_chk(input string tag, input logic [6:0] a, input logic [31:0] exp);
        step(0, 1, a, 32'h0, 4'h0);
        check(tag, bus_rdata, exp);
        check({tag, " model"}, exp_rd, exp);
    endtask

    function automatic logic exp_irq();
        return |(m_iflg & m_ien);
    endfunction

    task automatic chk_pins(input string tag);
        check({tag, " irq R8"}, {31'h0, irq}, {31'h0, exp_irq()});
        check({tag, " det_enable R2"}, {28'h0, det_enable}, {28'h0, m_en});
        check({tag, " det_active R2"}, {28'h0, det_active}, {28'h0, m_act});
        check({tag, " test_lock R9"}, {31'h0, test_lock}, {31'h0, m_lock});
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        check("R1 rdata", bus_rdata, 32'h0);
        chk_pins("R1");
        rd_chk("R1 ctl0", 7'h00, 32'h0);
        rd_chk("R1 iflg", 7'h40, 32'h0);

        // R2 control bits
        wr_reg(7'h10, 32'hFFFF_FFFF);
        chk_pins("R2 after ctl2 write");
        rd_chk("R2 ctl2 readback", 7'h10, 32'h0000_0011);
        wr_reg(7'h18, 32'h0000_0010);
        rd_chk("R2 ctl3 active only", 7'h18, 32'h0000_0010);

        // R3 disabled monitor ignores event
        step(0, 0, 7'h00, 0, 4'b0001);
        rd_chk("R3 sts0 ignored", 7'h04, 32'h0);
        rd_chk("R3 iflg ignored", 7'h40, 32'h0);
        // R3 enabled monitor latches
        wr_reg(7'h00, 32'h1);
        step(0, 0, 7'h00, 0, 4'b0001);
        rd_chk("R3 sts0 set", 7'h04, 32'h1);
        rd_chk("R3 iflg bit0", 7'h40, 32'h1);
        chk_pins("R3");

        // R4 W1C status
        wr_reg(7'h04, 32'hFFFF_FFFE);
        rd_chk("R4 write0 keeps", 7'h04, 32'h1);
        wr_reg(7'h04, 32'h1);
        rd_chk("R4 write1 clears", 7'h04, 32'h0);
        rd_chk("R4 iflg untouched", 7'h40, 32'h1);

        // R5 event beats clear (status and irq flag)
        step(1, 0, 7'h04, 32'h1, 4'b0001);
        rd_chk("R5 sts stays", 7'h04, 32'h1);
        step(1, 0, 7'h40, 32'h1, 4'b0001);
        rd_chk("R5 iflg stays", 7'h40, 32'h1);

        // R6 iflg W1C per bit, R7 ien, R8 irq
        step(0, 0, 7'h00, 0, 4'b0100);
        rd_chk("R6 iflg two bits", 7'h40, 32'h5);
        chk_pins("R8 no enable");
        wr_reg(7'h44, 32'hFFFF_FFF4);
        rd_chk("R7 ien readback", 7'h44, 32'h4);
        chk_pins("R8 enabled");
        check("R8 irq high", {31'h0, irq}, 32'h1);
        wr_reg(7'h40, 32'hFFFF_FFFB);
        rd_chk("R6 clear bit0 only", 7'h40, 32'h4);
        wr_reg(7'h40, 32'h4);
        check("R8 irq low", {31'h0, irq}, 32'h0);

        // R9 lock
        wr_reg(7'h20, 32'h0);
        rd_chk("R9 zero write", 7'h20, 32'h0);
        wr_reg(7'h20, 32'h8000_0000);
        rd_chk("R9 set", 7'h20, 32'h1);
        wr_reg(7'h20, 32'h0);
        wr_reg(7'h20, 32'hFFFF_FFFF);
        rd_chk("R9 sticky", 7'h20, 32'h1);
        chk_pins("R9");

        // R10 reserved
        wr_reg(7'h24, 32'hFFFF_FFFF);
        wr_reg(7'h01, 32'h0);
        wr_reg(7'h42, 32'hF);
        rd_chk("R10 rsvd 0x24", 7'h24, 32'h0);
        rd_chk("R10 rsvd 0x48", 7'h48, 32'h0);
        rd_chk("R10 misaligned", 7'h45, 32'h0);
        rd_chk("R10 ctl0 intact", 7'h00, 32'h1);
        rd_chk("R10 ien intact", 7'h44, 32'h4);

        // R11 idle rdata
        step(0, 0, 7'h44, 0, 4'h0);
        check("R11 idle zero", bus_rdata, 32'h0);

        // random phase
        for (int k = 0; k < 4000; k++) begin
            logic [6:0] a;
            logic [31:0] d;
            int sel = int'($urandom_range(0, 15));
            case (sel)
                0,1,2,3,4,5,6,7: a = 7'(sel * 4);
                8:  a = 7'h20;
                9:  a = 7'h40;
                10: a = 7'h44;
                11: a = 7'h24 + 7'($urandom_range(0, 6) * 4);
                12: a = 7'h48 + 7'($urandom_range(0, 13) * 4);
                13: a = 7'($urandom_range(0, 127)) | 7'h1;
                default: a = 7'h40;
            endcase
            d = ($urandom_range(0, 3) == 0) ? 32'h0 : $urandom;
            if (a == 7'h20 && $urandom_range(0, 7) != 0) d = 32'h0;
            step(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), a, d,
                 4'($urandom_range(0, 15)));
            check("R11 rand rdata", bus_rdata, exp_rd);
            check("R8 rand irq", {31'h0, irq}, {31'h0, exp_irq()});
            check("R2 rand det_enable", {28'h0, det_enable}, {28'h0, m_en});
            check("R2 rand det_active", {28'h0, det_active}, {28'h0, m_act});
        end

        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule